// File: doc/BRIEF.md
# Dual Polynomial CRC Engine

This block is a register-mapped checksum accelerator that takes CRC work off a processor. Software programs a control register that picks between a 16-bit CCITT generator and the 32-bit Ethernet generator, the per-write data size, and the input/output bit conventions. It then pushes data through a data register, one word per write, and reads the checksum back from a result register. Every access finishes in one clock, so writes can follow each other back to back and never stall.

The whole write is folded into the running remainder in the cycle it arrives, through byte stages chained in combinational logic. Writing the control register always reloads the remainder with the all-ones seed that belongs to the selected width. Reading the result shows the remainder after the selected output reflection and inversion and leaves the stored state alone.

Top module: `crc_accel`

## Requirements
- R1: Under the synchronous active-high reset the control register clears to 0 (16-bit mode, no reflection, no inversion, 1-byte writes), the remainder becomes 0x0000FFFF, and read data becomes 0.
- R2: Address 0 is the control register: bit 0 selects 32-bit mode, bit 1 reflects each input byte, bit 2 reflects the result, bit 3 inverts the result, bits 5:4 give the data size. A read returns these six bits with the upper bits zero. Reads of address 1 (data) and address 3 return zero.
- R3: A write to the control register loads the remainder with 0xFFFFFFFF in 32-bit mode or 0x0000FFFF in 16-bit mode.
- R4: In 16-bit mode the update uses generator 0x1021 and handles data most significant bit first. The bytes "123456789" give a result of 0x29B1 with no reflection and no inversion.
- R5: In 32-bit mode the update uses generator 0x04C11DB7. With input reflection, result reflection and inversion all set, the bytes "123456789" give 0xCBF43926.
- R6: The size field selects how many bytes of a data write are used: 0 gives bits 7:0, 1 gives bits 15:0, and 2 or 3 give all 32 bits. Bytes are folded from the most significant used byte down, so a multi-byte write gives the same result as the same bytes written one at a time.
- R7: A data write at address 1 updates the remainder in the same clock, and back-to-back writes are all absorbed with no wait state.
- R8: In 16-bit mode bits 31:16 of the remainder and of the result read back as zero.
- R9: Reading any register leaves the remainder and the control register unchanged.
- R10: Read data is registered. It shows the addressed register one cycle after a read and holds its value on every cycle that has no read.
- R11: Result reflection reverses the bit order over the selected width, and inversion XORs the result with all ones over that width. Each can be used alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address: 0 control, 1 data, 2 result |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The properties assume that each access lasts exactly one cycle, with address and write data valid whenever the strobe is high, and that the reset is held for at least one clock before the first access. They also assume that the upper bits of a control write above bit 5 carry no meaning. The stimulus drives every access for a single clock, away from the active edge. Its random phase mixes reads, writes and idle cycles at all four addresses, including control writes with arbitrary upper bits, so the seed, hold and narrow-mode rules are exercised under every control setting.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CRC_W    = 32;
  localparam int CFG_W    = 6;
  localparam logic [CRC_W-1:0] GEN32 = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] GEN16 = 32'h0000_1021;
  localparam logic [CRC_W-1:0] SEED32 = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] SEED16 = 32'h0000_FFFF;

  localparam int ADR_CTRL = 0;
  localparam int ADR_DATA = 1;
  localparam int ADR_RES  = 2;

  typedef struct packed {
    logic [1:0] size;   // 0: 1 byte, 1: 2 bytes, else full word
    logic       inv;    // invert result
    logic       rout;   // reflect result
    logic       rin;    // reflect each input byte
    logic       w32;    // 1: 32-bit generator, 0: 16-bit generator
  } crc_cfg_t;

  function automatic logic [7:0] flip8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_pkg::*;
(
  input  logic [CRC_W-1:0] rem_in,
  input  logic [7:0]       byte_in,
  input  logic             w32,
  input  logic             rin,
  input  logic             en,
  output logic [CRC_W-1:0] rem_out
);
  logic [CRC_W-1:0] cur;
  logic [7:0]       b;
  logic             fb;

  always_comb begin
    cur = rem_in;
    b   = rin ? flip8(byte_in) : byte_in;
    fb  = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      fb  = (w32 ? cur[31] : cur[15]) ^ b[i];
      cur = {cur[CRC_W-2:0], 1'b0};
      if (fb) cur = cur ^ (w32 ? GEN32 : GEN16);
      if (!w32) cur[31:16] = '0;
    end
    rem_out = en ? cur : rem_in;
  end
endmodule

// File: rtl/crc_fold.sv
module crc_fold
  import crc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [CRC_W-1:0]  rem_in,
  input  logic [DATA_W-1:0] data,
  input  crc_cfg_t          cfg,
  output logic [CRC_W-1:0]  rem_out
);
  localparam int LANES = DATA_W / 8;
  localparam int CW    = $clog2(LANES + 1) + 1;

  logic [CW-1:0]    nbytes;
  logic [CRC_W-1:0] chain [0:LANES];

  always_comb begin
    case (cfg.size)
      2'd0:    nbytes = CW'(1);
      2'd1:    nbytes = (LANES >= 2) ? CW'(2) : CW'(LANES);
      default: nbytes = (LANES >= 4) ? CW'(4) : CW'(LANES);
    endcase
  end

  assign chain[0] = rem_in;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LIDX = LANES - 1 - k;
    logic lane_en;
    assign lane_en = CW'(LIDX) < nbytes;
    crc_byte_step u_step (
      .rem_in  (chain[k]),
      .byte_in (data[8*LIDX +: 8]),
      .w32     (cfg.w32),
      .rin     (cfg.rin),
      .en      (lane_en),
      .rem_out (chain[k+1])
    );
  end

  assign rem_out = chain[LANES];
endmodule

// File: rtl/crc_out_xform.sv
module crc_out_xform
  import crc_pkg::*;
(
  input  logic [CRC_W-1:0] rem,
  input  logic             w32,
  input  logic             rout,
  input  logic             inv,
  output logic [CRC_W-1:0] res
);
  logic [CRC_W-1:0] rev32;
  logic [15:0]      rev16;

  always_comb begin
    for (int i = 0; i < CRC_W; i++) rev32[i] = rem[CRC_W-1-i];
    for (int i = 0; i < 16; i++)    rev16[i] = rem[15-i];
    res = w32 ? rem : {16'h0, rem[15:0]};
    if (rout) res = w32 ? rev32 : {16'h0, rev16};
    if (inv)  res = res ^ (w32 ? SEED32 : SEED16);
  end
endmodule

// File: rtl/crc_accel.sv
module crc_accel
  import crc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  crc_cfg_t         cfg_q;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] fold_out;
  logic [CRC_W-1:0] res_val;

  logic hit_ctrl, hit_data, hit_res;
  assign hit_ctrl = bus_addr == ADDR_W'(ADR_CTRL);
  assign hit_data = bus_addr == ADDR_W'(ADR_DATA);
  assign hit_res  = bus_addr == ADDR_W'(ADR_RES);

  crc_fold #(.DATA_W(DATA_W)) u_fold (
    .rem_in  (crc_q),
    .data    (bus_wdata),
    .cfg     (cfg_q),
    .rem_out (fold_out)
  );

  crc_out_xform u_xf (
    .rem  (crc_q),
    .w32  (cfg_q.w32),
    .rout (cfg_q.rout),
    .inv  (cfg_q.inv),
    .res  (res_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      crc_q <= SEED16;
    end else if (bus_sel && bus_wr) begin
      if (hit_ctrl) begin
        cfg_q <= crc_cfg_t'(bus_wdata[CFG_W-1:0]);
        crc_q <= bus_wdata[0] ? SEED32 : SEED16;
      end else if (hit_data) begin
        crc_q <= fold_out;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      if (hit_ctrl)     bus_rdata <= DATA_W'(cfg_q);
      else if (hit_res) bus_rdata <= DATA_W'(res_val);
      else              bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/crc_accel_chk.sv
module crc_accel_chk
  import crc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CRC_W-1:0]  crc_q,
  input crc_cfg_t          cfg_q
);
  logic ctrl_wr, rd, rd_res;
  assign ctrl_wr = bus_sel && bus_wr && bus_addr == ADDR_W'(ADR_CTRL);
  assign rd      = bus_sel && !bus_wr;
  assign rd_res  = rd && bus_addr == ADDR_W'(ADR_RES);

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> crc_q == ($past(bus_wdata[0]) ? SEED32 : SEED16)); // R3
  AST_CTRL_STORE: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> cfg_q == crc_cfg_t'($past(bus_wdata[CFG_W-1:0]))); // R2
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.w32 |-> crc_q[31:16] == 16'h0); // R8
  AST_NARROW_RESULT: assert property (@(posedge clk) disable iff (rst)
    (rd_res && !cfg_q.w32) |=> bus_rdata[31:16] == 16'h0); // R8
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
    rd |=> $stable(crc_q) && $stable(cfg_q)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata)); // R10
endmodule

bind crc_accel crc_accel_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .crc_q     (crc_q),
  .cfg_q     (cfg_q)
);

// File: tb/crc_accel_test.sv
module crc_accel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [5:0]  m_cfg = '0;
  logic [31:0] m_crc = 32'h0000FFFF;
  logic [31:0] m_rd = '0;

  always #10 clk = ~clk;

  crc_accel uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] m_byte(input logic [31:0] st, input logic [7:0] b,
                                         input bit w32, input bit rin);
    logic [7:0] bb;
    logic [31:0] s;
    bit fb;
    s = st;
    for (int i = 0; i < 8; i++) bb[i] = rin ? b[7-i] : b[i];
    for (int i = 7; i >= 0; i--) begin
      fb = (w32 ? s[31] : s[15]) ^ bb[i];
      s = s << 1;
      if (fb) s = s ^ (w32 ? 32'h04C11DB7 : 32'h00001021);
      if (!w32) s = s & 32'h0000FFFF;
    end
    return s;
  endfunction

  function automatic logic [31:0] m_result(input logic [31:0] st, input logic [5:0] c);
    logic [31:0] v;
    int w;
    w = c[0] ? 32 : 16;
    v = c[0] ? st : (st & 32'h0000FFFF);
    if (c[2]) begin
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < w; i++) r[i] = v[w-1-i];
      v = r;
    end
    if (c[3]) v = v ^ (c[0] ? 32'hFFFFFFFF : 32'h0000FFFF);
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input bit s, input bit w, input logic [1:0] a, input logic [31:0] d);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (s && !w) begin
      case (a)
        2'd0:    m_rd = {26'h0, m_cfg};
        2'd2:    m_rd = m_result(m_crc, m_cfg);
        default: m_rd = '0;
      endcase
    end else if (s && w && a == 2'd0) begin
      m_cfg = d[5:0];
      m_crc = d[0] ? 32'hFFFFFFFF : 32'h0000FFFF;
    end else if (s && w && a == 2'd1) begin
      int nb;
      nb = (d[5:4] == 0) ? 1 : 0;
      nb = (m_cfg[5:4] == 2'd0) ? 1 : (m_cfg[5:4] == 2'd1) ? 2 : 4;
      for (int k = nb - 1; k >= 0; k--) m_crc = m_byte(m_crc, d[8*k +: 8], m_cfg[0], m_cfg[1]);
    end
    @(negedge clk);
    bus_sel = 1'b0;
    check("R10 per-cycle read data vs model", bus_rdata, m_rd);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    op(1'b1, 1'b0, a, 32'h0);
    v = bus_rdata;
  endtask

  task automatic feed_digits(input int n);
    for (int i = 1; i <= n; i++) op(1'b1, 1'b1, 2'd1, 32'(8'h30 + i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, r_b, r_w, r_h, raw;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 read data after reset", bus_rdata, 32'h0);
    rd(2'd0, v); check("R1 control after reset", v, 32'h0);
    rd(2'd2, v); check("R1 result after reset", v, 32'h0000FFFF);

    // R4: CCITT check string
    op(1'b1, 1'b1, 2'd0, 32'h0);
    feed_digits(9);
    rd(2'd2, v); check("R4 CRC-16 of 123456789", v, 32'h000029B1);
    rd(2'd2, v); check("R9 second read unchanged", v, 32'h000029B1);
    check("R8 upper half zero in 16-bit mode", v & 32'hFFFF0000, 32'h0);

    // R5: Ethernet check string
    op(1'b1, 1'b1, 2'd0, 32'hFFFFFFC0 | 32'h0F);
    rd(2'd0, v); check("R2 control readback masks upper bits", v, 32'h0000000F);
    feed_digits(9);
    rd(2'd2, v); check("R5 CRC-32 of 123456789", v, 32'hCBF43926);
    rd(2'd1, v); check("R2 data address reads zero", v, 32'h0);
    rd(2'd3, v); check("R2 unused address reads zero", v, 32'h0);

    // R6: sizes agree
    op(1'b1, 1'b1, 2'd0, 32'h0F); feed_digits(8); rd(2'd2, r_b);
    op(1'b1, 1'b1, 2'd0, 32'h2F);
    op(1'b1, 1'b1, 2'd1, 32'h31323334); op(1'b1, 1'b1, 2'd1, 32'h35363738);
    rd(2'd2, r_w); check("R6 word writes equal byte writes", r_w, r_b);
    op(1'b1, 1'b1, 2'd0, 32'h1F);
    op(1'b1, 1'b1, 2'd1, 32'hAAAA3132); op(1'b1, 1'b1, 2'd1, 32'h55553334);
    op(1'b1, 1'b1, 2'd1, 32'h00003536); op(1'b1, 1'b1, 2'd1, 32'hFFFF3738);
    rd(2'd2, r_h); check("R6 half-word writes ignore upper bits", r_h, r_b);

    // R3: reseed
    op(1'b1, 1'b1, 2'd0, 32'h01);
    rd(2'd2, v); check("R3 32-bit seed", v, 32'hFFFFFFFF);
    op(1'b1, 1'b1, 2'd0, 32'h00);
    rd(2'd2, v); check("R3 16-bit seed", v, 32'h0000FFFF);

    // R11: output transforms alone
    op(1'b1, 1'b1, 2'd0, 32'h01); op(1'b1, 1'b1, 2'd1, 32'h5A); rd(2'd2, raw);
    op(1'b1, 1'b1, 2'd0, 32'h09); op(1'b1, 1'b1, 2'd1, 32'h5A); rd(2'd2, v);
    check("R11 inversion alone 32-bit", v, ~raw);
    op(1'b1, 1'b1, 2'd0, 32'h05); op(1'b1, 1'b1, 2'd1, 32'h5A); rd(2'd2, v);
    check("R11 reflection alone 32-bit", v, {<<{raw}});
    op(1'b1, 1'b1, 2'd0, 32'h00); op(1'b1, 1'b1, 2'd1, 32'h5A); rd(2'd2, raw);
    op(1'b1, 1'b1, 2'd0, 32'h08); op(1'b1, 1'b1, 2'd1, 32'h5A); rd(2'd2, v);
    check("R11 inversion alone 16-bit", v, raw ^ 32'h0000FFFF);

    // R7: back-to-back writes, R10: hold across idle
    op(1'b1, 1'b1, 2'd0, 32'h20);
    for (int i = 0; i < 6; i++) op(1'b1, 1'b1, 2'd1, 32'h01020304 * (i + 1));
    rd(2'd2, v); check("R7 back-to-back word writes", v, m_result(m_crc, m_cfg));
    op(1'b0, 1'b0, 2'd2, 32'h0); op(1'b1, 1'b1, 2'd1, 32'h1234);
    check("R10 read data held without read", bus_rdata, v);

    // random mix compared every cycle
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] d;
      d = $urandom;
      op(($urandom % 4) != 0, $urandom % 2, 2'($urandom % 4), d);
    end
    rd(2'd2, v); check("R7 final result after random mix", v, m_result(m_crc, m_cfg));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule